// File: doc/BRIEF.md
# I2C Multi-Master Bus-Busy Tracker

This block watches the SDA and SCL wires of a shared I2C bus on behalf of a controller that can be reset by software while other masters keep talking. It keeps a bus-busy flag and a sticky bus-free event flag. It also decides when the busy flag can be trusted. A controller that has just been reset cannot tell whether a transfer from another master is under way. The busy flag is therefore first loaded from the live line levels. It is trusted only after real bus activity has been seen, or after both lines have stayed high for a programmed quiet window.

The controller asks for this check with a one-cycle request strobe. It may start a transfer only while `start_ok` is high, meaning the busy flag is trusted and shows the bus free. If neither kind of evidence arrives within an overall check timeout, the block raises an error and never reports the bus ready. Another master holding SCL low is the typical cause. Each line passes through a flop synchronizer before any decision is taken. Driving the bus, shifting data and arbitration belong to other blocks.

Top module: `i2c_busy_tracker`

## Requirements
- R1: On the first enabled cycle after hard reset, after `soft_rst` or after `enable` rises, `busy` is loaded from the synchronized lines: 1 only for SDA=0 with SCL=1, and 0 for the other three combinations.
- R2: A START (synchronized SDA falls while synchronized SCL is high in both samples) sets `busy`.
- R3: SDA low while SCL is high sets `busy` even when no SDA edge occurred, for example when SCL rises while SDA is already low.
- R4: A STOP (synchronized SDA rises while SCL is high in both samples) clears `busy` and sets `bus_free`. `bus_free` stays set until a cycle with `free_clr`=1 clears it.
- R5: While `rst` is high, `enable` is low or `soft_rst` is high, the flags `busy`, `bus_free`, `busy_valid` and `check_timeout` are all 0 one cycle later.
- R6: Starting from an untrusted state, `busy_valid` rises once `busy` or `bus_free` has been seen at 1. It falls only through `soft_rst`, `enable` low or `rst`.
- R7: After `check_req`, `busy_valid` rises once both lines have been high for `QUIET_CYCLES` consecutive cycles. It stays 0 before that.
- R8: Any cycle with either synchronized line low during the check restarts the quiet count from zero.
- R9: If the check finds no evidence within `TIMEOUT_CYCLES`, `check_timeout` goes to 1 and `busy_valid` stays 0. A later `check_req` clears the error and starts a fresh check.
- R10: `start_ok` is 1 exactly when `busy_valid` is 1 and `busy` is 0.
- R11: A `check_req` that arrives while a check is running does not restart its timers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Block enable; low holds all flags cleared |
| soft_rst | input | 1 | Software reset of the tracker state |
| sda_in | input | 1 | Raw SDA level from the pad |
| scl_in | input | 1 | Raw SCL level from the pad |
| check_req | input | 1 | One-cycle request to qualify the busy flag |
| free_clr | input | 1 | Write-one-to-clear for the bus-free event |
| busy | output | 1 | Bus-busy flag |
| bus_free | output | 1 | Sticky STOP-seen event |
| busy_valid | output | 1 | Busy flag is trustworthy |
| start_ok | output | 1 | A new transfer may begin |
| check_timeout | output | 1 | Qualification check expired |

## Verification
The hardest case to reach from the ports is a foreign master holding SCL low across the whole check. The lines then never go idle and never show a START, ACK level or STOP, so only the overall timer can end the check. The bench places SDA high and SCL low before a soft reset, so `busy` loads as 0. It then requests a check and holds those levels past `TIMEOUT_CYCLES`. It confirms that `check_timeout` rises while `start_ok` stays low, and then that a retry on an idle bus recovers. A shortened quiet window lets it probe the exact edge of the window, a glitch on SCL that restarts the window, and a repeated request made partway through the window.

// File: rtl/i2cbt_pkg.sv
package i2cbt_pkg;

    // One sample of the two bus wires; sda is the upper bit.
    typedef struct packed {
        logic sda;
        logic scl;
    } line_pair_t;

    // Conditions decoded from two consecutive samples.
    typedef struct packed {
        logic start;
        logic stop;
        logic low_hold;
    } bus_evt_t;

    // Trust state of the busy flag.
    typedef enum logic [1:0] {
        VQ_UNSURE  = 2'd0,
        VQ_CHECK   = 2'd1,
        VQ_TRUSTED = 2'd2,
        VQ_EXPIRED = 2'd3
    } vq_state_t;

    // Busy value taken from bare levels: only SDA low with SCL high says busy.
    function automatic logic busy_from_levels(line_pair_t l);
        return (!l.sda) && l.scl;
    endfunction

    function automatic logic lines_idle(line_pair_t l);
        return l.sda && l.scl;
    endfunction

endpackage

// File: rtl/i2cbt_line_sync.sv
module i2cbt_line_sync
    import i2cbt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       sda_raw,
    input  logic       scl_raw,
    output line_pair_t cur,
    output line_pair_t prev
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0][1:0] pipe;
    line_pair_t         prev_q;

    // Idle bus (both high) is the reset value of every stage.
    always_ff @(posedge clk) begin
        if (rst) begin
            pipe   <= '1;
            prev_q <= '1;
        end else begin
            pipe[0] <= {sda_raw, scl_raw};
            for (int s = 1; s < STAGES; s++) begin
                pipe[s] <= pipe[s-1];
            end
            prev_q <= line_pair_t'(pipe[LAST]);
        end
    end

    assign cur  = line_pair_t'(pipe[LAST]);
    assign prev = prev_q;

endmodule

// File: rtl/i2cbt_cond_detect.sv
module i2cbt_cond_detect
    import i2cbt_pkg::*;
(
    input  line_pair_t cur,
    input  line_pair_t prev,
    output bus_evt_t   evt
);
    logic scl_steady_high;

    always_comb begin
        scl_steady_high = prev.scl && cur.scl;
        evt.start    = scl_steady_high && prev.sda && !cur.sda;
        evt.stop     = scl_steady_high && !prev.sda && cur.sda;
        evt.low_hold = busy_from_levels(cur);
    end

endmodule

// File: rtl/i2cbt_busy_track.sv
module i2cbt_busy_track
    import i2cbt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       soft_rst,
    input  logic       free_clr,
    input  line_pair_t cur,
    input  bus_evt_t   evt,
    output logic       busy,
    output logic       bus_free,
    output logic       load_pend
);
    logic hold;
    assign hold = !enable || soft_rst;

    always_ff @(posedge clk) begin
        if (rst || hold) begin
            busy      <= 1'b0;
            bus_free  <= 1'b0;
            load_pend <= 1'b1;
        end else if (load_pend) begin
            // First enabled cycle: take the flag from the wire levels.
            busy      <= busy_from_levels(cur);
            load_pend <= 1'b0;
        end else begin
            if (evt.stop) begin
                busy     <= 1'b0;
                bus_free <= 1'b1;
            end else begin
                if (evt.start || evt.low_hold) begin
                    busy <= 1'b1;
                end
                if (free_clr) begin
                    bus_free <= 1'b0;
                end
            end
        end
    end

endmodule

// File: rtl/i2cbt_valid_qual.sv
module i2cbt_valid_qual
    import i2cbt_pkg::*;
#(
    parameter int QUIET_CYCLES   = 1_000_000,
    parameter int TIMEOUT_CYCLES = 5_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable,
    input  logic       soft_rst,
    input  logic       check_req,
    input  logic       busy,
    input  logic       bus_free,
    input  line_pair_t cur,
    output logic       busy_valid,
    output logic       check_timeout
);
    localparam int QW = $clog2(QUIET_CYCLES + 1);
    localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [QW-1:0] Q_LAST = QW'(QUIET_CYCLES - 1);
    localparam logic [TW-1:0] T_LAST = TW'(TIMEOUT_CYCLES - 1);

    vq_state_t     state;
    logic [QW-1:0] quiet_cnt;
    logic [TW-1:0] wait_cnt;
    logic          activity;
    logic          idle_now;
    logic          quiet_done;
    logic          wait_done;

    always_comb begin
        activity   = busy || bus_free;
        idle_now   = lines_idle(cur);
        quiet_done = idle_now && (quiet_cnt == Q_LAST);
        wait_done  = (wait_cnt == T_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst || !enable || soft_rst) begin
            state     <= VQ_UNSURE;
            quiet_cnt <= '0;
            wait_cnt  <= '0;
        end else begin
            unique case (state)
                VQ_UNSURE, VQ_EXPIRED: begin
                    if (activity) begin
                        state <= VQ_TRUSTED;
                    end else if (check_req) begin
                        state     <= VQ_CHECK;
                        quiet_cnt <= '0;
                        wait_cnt  <= '0;
                    end
                end
                VQ_CHECK: begin
                    if (activity || quiet_done) begin
                        state <= VQ_TRUSTED;
                    end else if (wait_done) begin
                        state <= VQ_EXPIRED;
                    end else begin
                        quiet_cnt <= idle_now ? quiet_cnt + 1'b1 : '0;
                        wait_cnt  <= wait_cnt + 1'b1;
                    end
                end
                default: state <= VQ_TRUSTED;
            endcase
        end
    end

    assign busy_valid    = (state == VQ_TRUSTED);
    assign check_timeout = (state == VQ_EXPIRED);

endmodule

// File: rtl/i2c_busy_tracker.sv
module i2c_busy_tracker
    import i2cbt_pkg::*;
#(
    parameter int SYNC_STAGES    = 2,
    parameter int QUIET_CYCLES   = 1_000_000,
    parameter int TIMEOUT_CYCLES = 5_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic soft_rst,
    input  logic sda_in,
    input  logic scl_in,
    input  logic check_req,
    input  logic free_clr,
    output logic busy,
    output logic bus_free,
    output logic busy_valid,
    output logic start_ok,
    output logic check_timeout
);
    line_pair_t cur_lines;
    line_pair_t prev_lines;
    bus_evt_t   evt;
    logic       load_pend;

    i2cbt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .sda_raw (sda_in),
        .scl_raw (scl_in),
        .cur     (cur_lines),
        .prev    (prev_lines)
    );

    i2cbt_cond_detect u_detect (
        .cur  (cur_lines),
        .prev (prev_lines),
        .evt  (evt)
    );

    i2cbt_busy_track u_track (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .soft_rst  (soft_rst),
        .free_clr  (free_clr),
        .cur       (cur_lines),
        .evt       (evt),
        .busy      (busy),
        .bus_free  (bus_free),
        .load_pend (load_pend)
    );

    i2cbt_valid_qual #(
        .QUIET_CYCLES   (QUIET_CYCLES),
        .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
    ) u_qual (
        .clk           (clk),
        .rst           (rst),
        .enable        (enable),
        .soft_rst      (soft_rst),
        .check_req     (check_req),
        .busy          (busy),
        .bus_free      (bus_free),
        .cur           (cur_lines),
        .busy_valid    (busy_valid),
        .check_timeout (check_timeout)
    );

    assign start_ok = busy_valid && !busy;

endmodule

// File: rtl/i2cbt_checker.sv
module i2cbt_checker
    import i2cbt_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       enable,
    input logic       soft_rst,
    input line_pair_t cur_lines,
    input line_pair_t prev_lines,
    input logic       load_pend,
    input logic       busy,
    input logic       bus_free,
    input logic       busy_valid,
    input logic       check_timeout
);
    logic run, saw_stop, saw_low;
    assign run      = enable && !soft_rst && !load_pend;
    assign saw_stop = prev_lines.scl && cur_lines.scl && !prev_lines.sda && cur_lines.sda;
    assign saw_low  = cur_lines.scl && !cur_lines.sda;

    assert_level_load_R1: assert property (@(posedge clk) disable iff (rst)
        (enable && !soft_rst && load_pend) |=> (busy == $past(saw_low)));

    assert_ack_level_R3: assert property (@(posedge clk) disable iff (rst)
        (run && saw_low) |=> busy);

    assert_stop_frees_R4: assert property (@(posedge clk) disable iff (rst)
        (run && saw_stop) |=> (!busy && bus_free));

    assert_hold_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (!enable || soft_rst) |=> (!busy && !bus_free && !busy_valid && !check_timeout));

    assert_valid_drop_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_valid) |-> $past(!enable || soft_rst || rst));

    assert_quiet_expiry_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(check_timeout) |-> $past(!busy && !bus_free));

endmodule

bind i2c_busy_tracker i2cbt_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .enable        (enable),
    .soft_rst      (soft_rst),
    .cur_lines     (cur_lines),
    .prev_lines    (prev_lines),
    .load_pend     (load_pend),
    .busy          (busy),
    .bus_free      (bus_free),
    .busy_valid    (busy_valid),
    .check_timeout (check_timeout)
);

// File: tb/tb_i2c_busy_tracker.sv
module tb_i2c_busy_tracker;
    localparam int QC = 40;
    localparam int TC = 200;

    logic clk = 1'b0;
    logic rst, enable, soft_rst, sda_in, scl_in, check_req, free_clr;
    logic busy, bus_free, busy_valid, start_ok, check_timeout;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    typedef struct {
        string tag;
        logic  b, f, v, o, t;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    i2c_busy_tracker #(
        .SYNC_STAGES(2), .QUIET_CYCLES(QC), .TIMEOUT_CYCLES(TC)
    ) dut (
        .clk(clk), .rst(rst), .enable(enable), .soft_rst(soft_rst),
        .sda_in(sda_in), .scl_in(scl_in), .check_req(check_req),
        .free_clr(free_clr), .busy(busy), .bus_free(bus_free),
        .busy_valid(busy_valid), .start_ok(start_ok),
        .check_timeout(check_timeout)
    );

    // Monitor: pops one expected item per falling edge and compares.
    always @(negedge clk) begin
        if (exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            total++;
            if ({busy, bus_free, busy_valid, start_ok, check_timeout} !==
                {e.b, e.f, e.v, e.o, e.t}) begin
                bad++;
                $display("FAIL %s: got busy/free/valid/ok/tmo=%b%b%b%b%b expected %b%b%b%b%b",
                         e.tag, busy, bus_free, busy_valid, start_ok, check_timeout,
                         e.b, e.f, e.v, e.o, e.t);
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side of the scoreboard: queue an expectation for the next falling edge.
    task automatic expect_out(input string tag, input logic b, f, v, o, t);
        exp_t e;
        #1;
        e.tag = tag; e.b = b; e.f = f; e.v = v; e.o = o; e.t = t;
        exp_q.push_back(e);
        @(negedge clk);
    endtask

    task automatic pulse_req();
        check_req = 1'b1;
        tick(1);
        check_req = 1'b0;
    endtask

    task automatic do_soft_reset();
        soft_rst = 1'b1;
        tick(1);
        soft_rst = 1'b0;
        tick(3);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hung run expected completion");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; enable = 1'b0; soft_rst = 1'b0; sda_in = 1'b1; scl_in = 1'b1;
        check_req = 1'b0; free_clr = 1'b0;
        tick(3);
        expect_out("R5 reset state", 0, 0, 0, 0, 0);
        rst = 1'b0;

        // R1: ACK-like levels while disabled, then enable
        sda_in = 1'b0; scl_in = 1'b1;
        tick(4);
        expect_out("R5 disabled", 0, 0, 0, 0, 0);
        enable = 1'b1;
        tick(3);
        expect_out("R1 load sda0 scl1 / R6 valid", 1, 0, 1, 0, 0);
        enable = 1'b0;
        tick(2);
        expect_out("R5 enable low clears", 0, 0, 0, 0, 0);

        // R1: both low loads 0; then R3 SCL rises with SDA low
        sda_in = 1'b0; scl_in = 1'b0;
        tick(4);
        enable = 1'b1;
        tick(3);
        expect_out("R1 load sda0 scl0", 0, 0, 0, 0, 0);
        scl_in = 1'b1;
        tick(4);
        expect_out("R3 ack level / R6", 1, 0, 1, 0, 0);
        sda_in = 1'b1;
        tick(4);
        expect_out("R4 stop / R10", 0, 1, 1, 1, 0);
        free_clr = 1'b1;
        tick(1);
        free_clr = 1'b0;
        tick(1);
        expect_out("R4 free_clr", 0, 0, 1, 1, 0);

        // R1/R6: soft reset on idle lines loads 0, validity lost
        soft_rst = 1'b1;
        tick(1);
        expect_out("R5 soft reset", 0, 0, 0, 0, 0);
        soft_rst = 1'b0;
        tick(3);
        expect_out("R1 load idle / R6 cleared", 0, 0, 0, 0, 0);

        // R7 quiet window, R11 repeated request ignored
        pulse_req();
        tick(19);
        pulse_req();
        tick(QC - 3 - 20);
        expect_out("R7 before window / R11", 0, 0, 0, 0, 0);
        tick(2);
        expect_out("R7 window reached / R11 / R10", 0, 0, 1, 1, 0);

        // R8 SCL glitch restarts the window
        do_soft_reset();
        pulse_req();
        tick(15);
        scl_in = 1'b0;
        tick(3);
        scl_in = 1'b1;
        tick(QC - 18);
        expect_out("R8 restart delays valid", 0, 0, 0, 0, 0);
        tick(21);
        expect_out("R8 valid after restart", 0, 0, 1, 1, 0);

        // R9 SCL held low by another master: timeout
        scl_in = 1'b0;
        do_soft_reset();
        expect_out("R1 load sda1 scl0", 0, 0, 0, 0, 0);
        pulse_req();
        tick(TC - 3 - 1);
        expect_out("R9 before timeout", 0, 0, 0, 0, 0);
        tick(2);
        expect_out("R9 timeout / R10 no start", 0, 0, 0, 0, 1);
        scl_in = 1'b1;
        tick(3);
        expect_out("R9 error held", 0, 0, 0, 0, 1);
        pulse_req();
        expect_out("R9 retry clears error", 0, 0, 0, 0, 0);
        tick(QC);
        expect_out("R9 retry qualifies", 0, 0, 1, 1, 0);

        // R2 START then STOP, then disable
        sda_in = 1'b0;
        tick(4);
        expect_out("R2 start / R10", 1, 0, 1, 0, 0);
        sda_in = 1'b1;
        tick(4);
        expect_out("R4 stop after start", 0, 1, 1, 1, 0);
        enable = 1'b0;
        tick(2);
        expect_out("R5 disable clears free", 0, 0, 0, 0, 0);

        tick(2);
        finished = 1'b1;
        finish_run();
    end

endmodule